// File: doc/BRIEF.md
# Vector-Extension Prefix Decoder

This block watches an instruction byte stream, one byte per cycle in which `in_valid` is high. It recognises the two-byte (lead byte C5h) and three-byte (lead byte C4h) vector-extension prefix forms and pulls out two things. One is the operand-size bit W. The other is the number of the extra source register, which the prefix stores in inverted form. The caller supplies the CPU mode and two properties of the opcode class: whether the instruction reads the extra register field, and how it treats W. These inputs are sampled together with the final prefix byte.

When a prefix completes, a one-cycle `done` pulse carries the decoded record. An invalid-opcode fault rides on the same pulse and overrides the record. In 32-bit and 16-bit modes, the lead bytes C4h and C5h are also legacy far-pointer load opcodes. If the byte after the lead byte does not have both top bits set, the block emits a one-cycle `legacy` pulse instead, and `legacy_lds` tells which of the two opcodes it was. A build parameter selects how a narrow mode treats the top register-field bit of the three-byte form. By default that bit is ignored. In the strict variant it is decoded, and a register above 7 is flagged as unusable.

Top module: `vecpfx_decoder`

## Requirements
- R1: A synchronous active-high `rst` returns the decoder to waiting for a lead byte and drives every output to zero from the next edge on, including in the middle of a prefix.
- R2: Lead byte C5h followed by byte B gives, one cycle after B is accepted: `done`=1, `three_byte`=0, `w_bit`=0, `src_reg` = bitwise inverse of B[6:3].
- R3: Lead byte C4h followed by bytes B1 and B2 gives, one cycle after B2 is accepted: `done`=1, `three_byte`=1, `src_reg` = inverse of B2[6:3], and a raw W taken from B2[7]. B1 only takes part in the R4 check.
- R4: With `mode64`=0, if the byte after a lead byte has bits [7:6] other than 11b, the next cycle shows `legacy`=1, `done`=0, and `legacy_lds`=1 for lead C5h or 0 for C4h. With `mode64`=1 there is no fallback.
- R5: `w_class` encodings: 0 = size-promoting, so `w_bit` equals the raw W in 64-bit mode and is 0 otherwise; 1 = don't-care, so `w_bit`=0 and W never faults; 2 or 3 = reserved, so a raw W of 1 raises `ud_fault`. The two-byte form has a raw W of 0.
- R6: With `uses_src`=0, a register field other than 1111b raises `ud_fault`.
- R7: With `mode64`=0 in the three-byte form, B2[6] is read as 1 by default, so `src_reg` is below 8 and `reg_bad`=0. With `STRICT_NARROW`=1 the bit is decoded and `reg_bad`=1 whenever `src_reg` is 8 or more.
- R8: When `ud_fault`=1, `done`=1 and `w_bit`, `src_reg` and `reg_bad` are all 0.
- R9: Bytes with `in_valid`=0 are ignored. While waiting for a lead byte, every byte other than C4h or C5h is ignored and produces no output.
- R10: `done` and `legacy` are high for exactly one cycle, and all record outputs are 0 outside those cycles. A new lead byte is accepted in the cycle that the previous pulse is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | `in_byte` carries a stream byte this cycle |
| in_byte | input | 8 | Instruction stream byte |
| mode64 | input | 1 | 1 = 64-bit mode, 0 = 32-bit or 16-bit mode |
| uses_src | input | 1 | Opcode class reads the extra source register field |
| w_class | input | 2 | W handling: 0 promoting, 1 don't-care, 2/3 reserved |
| done | output | 1 | One-cycle strobe: a prefix was decoded |
| legacy | output | 1 | One-cycle strobe: legacy far-pointer load |
| legacy_lds | output | 1 | With `legacy`: 1 = C5h opcode, 0 = C4h opcode |
| ud_fault | output | 1 | With `done`: invalid-opcode fault |
| reg_bad | output | 1 | With `done`: register not usable in this mode |
| three_byte | output | 1 | With `done`: three-byte form |
| w_bit | output | 1 | With `done`: effective operand-size bit |
| src_reg | output | 4 | With `done`: extra source register number |

## Verification
Directed sequences give each form a known register field. They show that the inversion and the byte position are right, and they split the C4h and C5h paths. Narrow-mode cases set the top bits of the second byte to 11b or not, which separates legacy fallback from decode. The same bytes sent in 64-bit mode show that the fallback depends on the mode. W and register-field cases go through every `w_class` value and both `uses_src` values, in both modes, to tell apart promotion, ignoring and faulting. Random sequences, sent to a default instance and a strict instance at once, mix all of these and compare them against a bench model. Directed stream cases cover invalid gaps, non-prefix bytes, a reset in the middle of a prefix and back-to-back prefixes.

// File: rtl/vecpfx_pkg.sv
package vecpfx_pkg;

    localparam int BYTE_W = 8;
    localparam int VREG_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WAIT_B1 = 2'd1,
        ST_WAIT_B2 = 2'd2
    } pfx_state_e;

    localparam logic [1:0] WC_PROMOTE  = 2'd0;
    localparam logic [1:0] WC_IGNORE   = 2'd1;
    localparam logic [1:0] WC_RESERVED = 2'd2;

    typedef struct packed {
        logic              done;
        logic              legacy;
        logic              legacy_lds;
        logic              ud_fault;
        logic              reg_bad;
        logic              three_byte;
        logic              w_bit;
        logic [VREG_W-1:0] src_reg;
    } pfx_out_t;

    typedef struct packed {
        pfx_state_e st;
        logic       form3;
        pfx_out_t   out;
    } pfx_reg_t;

endpackage

// File: rtl/vecpfx_compat_check.sv
module vecpfx_compat_check (
    input  logic       mode64,
    input  logic [1:0] top_bits,
    output logic       fallback
);
    // Narrow modes treat the sequence as the legacy opcode unless both top bits are set
    always_comb fallback = !mode64 && (top_bits != 2'b11);
endmodule

// File: rtl/vecpfx_field_decode.sv
module vecpfx_field_decode
    import vecpfx_pkg::*;
#(
    parameter bit STRICT_NARROW = 1'b0
) (
    input  logic [VREG_W:0]   fld,        // byte bits [7:3]
    input  logic              three_byte,
    input  logic              mode64,
    input  logic              uses_src,
    input  logic [1:0]        w_class,
    output logic              fault,
    output logic              w_eff,
    output logic [VREG_W-1:0] reg_num,
    output logic              reg_bad
);
    localparam int HI = VREG_W - 1;

    logic [VREG_W-1:0] raw_field;
    logic [VREG_W-1:0] eff_field;
    logic              hi_eff;
    logic              w_raw;
    logic              w_fault;
    logic              v_fault;

    assign raw_field = fld[VREG_W-1:0];

    generate
        if (STRICT_NARROW) begin : g_strict
            assign hi_eff = raw_field[HI];
        end else begin : g_ignore
            // top field bit of the three-byte form is read as one in narrow modes
            assign hi_eff = raw_field[HI] | (three_byte & ~mode64);
        end
    endgenerate

    always_comb begin
        eff_field = {hi_eff, raw_field[HI-1:0]};
        w_raw     = three_byte & fld[VREG_W];
        w_fault   = (w_class != WC_PROMOTE) && (w_class != WC_IGNORE) && w_raw;
        v_fault   = !uses_src && (eff_field != {VREG_W{1'b1}});
        fault     = w_fault || v_fault;
        w_eff     = (w_class == WC_PROMOTE) && mode64 && w_raw;
        reg_num   = ~eff_field;
        reg_bad   = !mode64 && reg_num[HI];
    end
endmodule

// File: rtl/vecpfx_decoder.sv
module vecpfx_decoder
    import vecpfx_pkg::*;
#(
    parameter logic [7:0] PFX_THREE     = 8'hC4,
    parameter logic [7:0] PFX_TWO       = 8'hC5,
    parameter bit         STRICT_NARROW = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              mode64,
    input  logic              uses_src,
    input  logic [1:0]        w_class,
    output logic              done,
    output logic              legacy,
    output logic              legacy_lds,
    output logic              ud_fault,
    output logic              reg_bad,
    output logic              three_byte,
    output logic              w_bit,
    output logic [VREG_W-1:0] src_reg
);
    pfx_reg_t dec_d, dec_q;

    logic              fallback;
    logic              f_fault;
    logic              f_w;
    logic [VREG_W-1:0] f_reg;
    logic              f_bad;
    logic              at_b2;
    pfx_out_t          rec;

    assign at_b2 = (dec_q.st == ST_WAIT_B2);

    vecpfx_compat_check u_compat (
        .mode64   (mode64),
        .top_bits (in_byte[BYTE_W-1:BYTE_W-2]),
        .fallback (fallback)
    );

    vecpfx_field_decode #(
        .STRICT_NARROW (STRICT_NARROW)
    ) u_field (
        .fld        (in_byte[BYTE_W-1:BYTE_W-1-VREG_W]),
        .three_byte (at_b2),
        .mode64     (mode64),
        .uses_src   (uses_src),
        .w_class    (w_class),
        .fault      (f_fault),
        .w_eff      (f_w),
        .reg_num    (f_reg),
        .reg_bad    (f_bad)
    );

    // decoded record for a final byte; a fault wipes the payload
    always_comb begin
        rec            = '0;
        rec.done       = 1'b1;
        rec.three_byte = dec_q.form3;
        rec.ud_fault   = f_fault;
        if (!f_fault) begin
            rec.w_bit   = f_w;
            rec.src_reg = f_reg;
            rec.reg_bad = f_bad;
        end
    end

    always_comb begin
        dec_d     = dec_q;
        dec_d.out = '0;
        if (in_valid) begin
            unique case (dec_q.st)
                ST_IDLE: begin
                    if (in_byte == PFX_THREE) begin
                        dec_d.st    = ST_WAIT_B1;
                        dec_d.form3 = 1'b1;
                    end else if (in_byte == PFX_TWO) begin
                        dec_d.st    = ST_WAIT_B1;
                        dec_d.form3 = 1'b0;
                    end
                end
                ST_WAIT_B1: begin
                    if (fallback) begin
                        dec_d.st             = ST_IDLE;
                        dec_d.out.legacy     = 1'b1;
                        dec_d.out.legacy_lds = !dec_q.form3;
                    end else if (!dec_q.form3) begin
                        dec_d.st  = ST_IDLE;
                        dec_d.out = rec;
                    end else begin
                        dec_d.st = ST_WAIT_B2;
                    end
                end
                ST_WAIT_B2: begin
                    dec_d.st  = ST_IDLE;
                    dec_d.out = rec;
                end
                default: dec_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_q <= '{st: ST_IDLE, form3: 1'b0, out: '0};
        end else begin
            dec_q <= dec_d;
        end
    end

    assign done       = dec_q.out.done;
    assign legacy     = dec_q.out.legacy;
    assign legacy_lds = dec_q.out.legacy_lds;
    assign ud_fault   = dec_q.out.ud_fault;
    assign reg_bad    = dec_q.out.reg_bad;
    assign three_byte = dec_q.out.three_byte;
    assign w_bit      = dec_q.out.w_bit;
    assign src_reg    = dec_q.out.src_reg;
endmodule

// File: rtl/vecpfx_decoder_chk.sv
module vecpfx_decoder_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       mode64,
    input logic       done,
    input logic       legacy,
    input logic       legacy_lds,
    input logic       ud_fault,
    input logic       reg_bad,
    input logic       three_byte,
    input logic       w_bit,
    input logic [3:0] src_reg
);
    // R10
    no_double_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !(done && legacy));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    legacy_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        legacy |=> !legacy);

    // R4
    legacy_narrow_chk: assert property (@(posedge clk) disable iff (rst)
        legacy |-> (!$past(mode64) && $past(in_valid)));

    // R9
    done_needs_byte_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(in_valid));

    // R8
    fault_payload_chk: assert property (@(posedge clk) disable iff (rst)
        ud_fault |-> (done && !w_bit && !reg_bad && (src_reg == 4'd0)));

    // R10
    quiet_record_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> (!ud_fault && !reg_bad && !three_byte && !w_bit && (src_reg == 4'd0)));

    // R4
    lds_only_legacy_chk: assert property (@(posedge clk) disable iff (rst)
        legacy_lds |-> legacy);

    // R7
    reg_bad_narrow_chk: assert property (@(posedge clk) disable iff (rst)
        reg_bad |-> (done && src_reg[3] && !$past(mode64)));

    // R5
    w_narrow_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !$past(mode64)) |-> !w_bit);
endmodule

bind vecpfx_decoder vecpfx_decoder_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .mode64     (mode64),
    .done       (done),
    .legacy     (legacy),
    .legacy_lds (legacy_lds),
    .ud_fault   (ud_fault),
    .reg_bad    (reg_bad),
    .three_byte (three_byte),
    .w_bit      (w_bit),
    .src_reg    (src_reg)
);

// File: tb/vecpfx_decoder_tb.sv
`timescale 1ns/1ps
module vecpfx_decoder_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       mode64 = 1'b1;
    logic       uses_src = 1'b1;
    logic [1:0] w_class = 2'd0;

    logic       d_a, l_a, s_a, f_a, b_a, t_a, w_a;
    logic [3:0] r_a;
    logic       d_b, l_b, s_b, f_b, b_b, t_b, w_b;
    logic [3:0] r_b;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    vecpfx_decoder u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .mode64(mode64), .uses_src(uses_src), .w_class(w_class),
        .done(d_a), .legacy(l_a), .legacy_lds(s_a), .ud_fault(f_a),
        .reg_bad(b_a), .three_byte(t_a), .w_bit(w_a), .src_reg(r_a)
    );

    vecpfx_decoder #(.STRICT_NARROW(1'b1)) u_dut_strict (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .mode64(mode64), .uses_src(uses_src), .w_class(w_class),
        .done(d_b), .legacy(l_b), .legacy_lds(s_b), .ud_fault(f_b),
        .reg_bad(b_b), .three_byte(t_b), .w_bit(w_b), .src_reg(r_b)
    );

    // packed view: {done, legacy, lds, fault, bad, three, w, reg[3:0]}
    wire [10:0] obs_a = {d_a, l_a, s_a, f_a, b_a, t_a, w_a, r_a};
    wire [10:0] obs_b = {d_b, l_b, s_b, f_b, b_b, t_b, w_b, r_b};

    task automatic chk(input string tag, input logic [10:0] act, input logic [10:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%03h expected=%03h", tag, act, exp);
        end
    endtask

    function automatic logic [10:0] model(input bit form3, input logic [7:0] b1,
                                          input logic [7:0] b2, input bit m64,
                                          input bit uses, input logic [1:0] wc,
                                          input bit strict);
        logic [7:0] fin;
        logic [3:0] raw;
        logic [3:0] rn;
        bit wr, flt, we, bad;
        if (!m64 && b1[7:6] != 2'b11)
            return {1'b0, 1'b1, !form3, 8'h00};
        fin = form3 ? b2 : b1;
        raw = fin[6:3];
        if (form3 && !m64 && !strict) raw[3] = 1'b1;
        wr  = form3 && fin[7];
        flt = (!uses && raw != 4'hF) || (wc >= 2'd2 && wr);
        we  = (wc == 2'd0) && m64 && wr;
        rn  = ~raw;
        bad = !m64 && rn[3];
        if (flt) return {1'b1, 1'b0, 1'b0, 1'b1, 1'b0, form3, 1'b0, 4'h0};
        return {1'b1, 1'b0, 1'b0, 1'b0, bad, form3, we, rn};
    endfunction

    task automatic drive(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
    endtask

    task automatic idle_cyc();
        @(negedge clk);
        in_valid = 1'b0;
        in_byte  = 8'h00;
    endtask

    task automatic run(input string tag, input bit form3, input logic [7:0] b1,
                       input logic [7:0] b2, input bit m64, input bit uses,
                       input logic [1:0] wc);
        bit fb;
        mode64   = m64;
        uses_src = uses;
        w_class  = wc;
        fb = !m64 && (b1[7:6] != 2'b11);
        drive(form3 ? 8'hC4 : 8'hC5);
        drive(b1);
        if (form3 && !fb) drive(b2);
        idle_cyc();
        chk(tag, obs_a, model(form3, b1, b2, m64, uses, wc, 1'b0));
        chk({tag, " strict"}, obs_b, model(form3, b1, b2, m64, uses, wc, 1'b1));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset", obs_a, 11'h000);
        chk("R1 reset strict", obs_b, 11'h000);
        @(negedge clk);
        rst = 1'b0;

        // R2 two-byte form, field 1001b -> register 6
        run("R2", 1'b0, 8'hC8, 8'h00, 1'b1, 1'b1, 2'd0);
        // R3 three-byte form, field 0110b -> register 9
        run("R3", 1'b1, 8'hE2, 8'h35, 1'b1, 1'b1, 2'd0);
        // R4 legacy fallback and its absence in 64-bit mode
        run("R4 les", 1'b1, 8'h12, 8'h00, 1'b0, 1'b1, 2'd0);
        run("R4 lds", 1'b0, 8'h80, 8'h00, 1'b0, 1'b1, 2'd0);
        run("R4 wide", 1'b0, 8'h12, 8'h00, 1'b1, 1'b1, 2'd0);
        // R5 W classes with W=1
        run("R5 promote64", 1'b1, 8'hE1, 8'hF8, 1'b1, 1'b1, 2'd0);
        run("R5 promote32", 1'b1, 8'hE1, 8'hF8, 1'b0, 1'b1, 2'd0);
        run("R5 dontcare", 1'b1, 8'hE1, 8'hF8, 1'b1, 1'b1, 2'd1);
        run("R5 reserved", 1'b1, 8'hE1, 8'hF8, 1'b1, 1'b1, 2'd2);
        run("R5 reserved w0", 1'b1, 8'hE1, 8'h78, 1'b1, 1'b1, 2'd3);
        // R6 unused field must be 1111b; R8 fault clears payload
        run("R6 R8 bad field", 1'b1, 8'hE1, 8'h70, 1'b1, 1'b0, 2'd1);
        run("R6 good field", 1'b0, 8'hF8, 8'h00, 1'b1, 1'b0, 2'd0);
        // R7 narrow three-byte with field bit 6 clear
        run("R7", 1'b1, 8'hE1, 8'h38, 1'b0, 1'b1, 2'd0);
        run("R7 unused", 1'b1, 8'hE1, 8'h38, 1'b0, 1'b0, 2'd0);

        // R9 gaps and non-prefix bytes are ignored
        mode64 = 1'b1; uses_src = 1'b1; w_class = 2'd0;
        @(negedge clk); in_valid = 1'b0; in_byte = 8'hC4;
        @(negedge clk); in_valid = 1'b1; in_byte = 8'h90;
        @(negedge clk); in_valid = 1'b1; in_byte = 8'h0F;
        @(negedge clk);
        chk("R9 quiet", obs_a, 11'h000);
        in_valid = 1'b1; in_byte = 8'hC5;
        @(negedge clk); in_valid = 1'b0; in_byte = 8'hC4;
        @(negedge clk); in_valid = 1'b1; in_byte = 8'hB0;
        @(negedge clk); in_valid = 1'b0;
        chk("R9 gap", obs_a, model(1'b0, 8'hB0, 8'h00, 1'b1, 1'b1, 2'd0, 1'b0));

        // R10 back-to-back prefixes and one-cycle pulses
        drive(8'hC5); drive(8'hF0);
        @(negedge clk);
        chk("R10 first", obs_a, model(1'b0, 8'hF0, 8'h00, 1'b1, 1'b1, 2'd0, 1'b0));
        in_valid = 1'b1; in_byte = 8'hC5;
        @(negedge clk);
        chk("R10 drop", obs_a, 11'h000);
        in_byte = 8'h88;
        @(negedge clk); in_valid = 1'b0;
        chk("R10 second", obs_a, model(1'b0, 8'h88, 8'h00, 1'b1, 1'b1, 2'd0, 1'b0));
        @(negedge clk);
        chk("R10 clear", obs_a, 11'h000);

        // R1 reset in the middle of a prefix
        drive(8'hC5);
        @(negedge clk); rst = 1'b1; in_valid = 1'b1; in_byte = 8'hF8;
        @(negedge clk); rst = 1'b0; in_valid = 1'b0;
        chk("R1 mid reset", obs_a, 11'h000);
        drive(8'hF8); idle_cyc();
        chk("R1 after reset", obs_a, 11'h000);

        // random mix for R2 R3 R4 R5 R6 R7
        void'($urandom(32'd1234));
        for (int i = 0; i < 400; i++) begin
            logic [7:0] rb1, rb2;
            bit f3, m, u;
            logic [1:0] wc;
            f3  = $urandom_range(0, 1);
            m   = $urandom_range(0, 1);
            u   = $urandom_range(0, 3) != 0;
            wc  = 2'($urandom_range(0, 3));
            rb1 = 8'($urandom);
            rb2 = 8'($urandom);
            if ($urandom_range(0, 3) != 0) rb1[7:6] = 2'b11;
            if (!u && $urandom_range(0, 1) == 1) begin
                rb1[6:3] = 4'hF;
                rb2[6:3] = 4'hF;
            end
            run("R2 R3 R5 random", f3, rb1, rb2, m, u, wc);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule